// File: doc/BRIEF.md
# Character Display Controller Host Read Port

This block is the host-facing side of a character display controller. The host writes instructions and reads results over a narrow port. That port has an instruction strobe, a two-bit register select, a read/write flag and a data byte. One address counter is shared by three internal memories: the character-code (display) memory, the attribute memory and the glyph-pattern memory. The memory the counter refers to is whichever region the most recent address-set instruction chose.

Data reads come from a prefetch latch. An address set, a shift command or a data read reloads the latch from the selected memory at the new counter value, so the next data read returns the byte at the address before its own step. A status read returns a busy flag together with the counter.

Every accepted instruction except a status read keeps the port busy for a fixed number of oscillator-enable ticks. While the port is busy, every instruction other than a status read is dropped, so the host polls the flag before it issues more work. The three memories are fixed at start-up from arithmetic fill patterns, which makes read data predictable:
- display entry i = (3i+1) mod 256
- attribute entry i = i XOR 0xA5
- glyph entry i = (7i+64) mod 256

Top module: `lcdc_host_rd`

## Requirements
- R1: After reset, a status read returns 0x00 (idle, counter 0), the display memory is selected and the step direction is upward. The first data read returns display entry 0.
- R2: A status read (rs=10, rw=1) returns {busy, counter[6:0]} on the next cycle. It is always accepted and never makes the port busy.
- R3: Every other accepted instruction raises busy on the following cycle. Busy clears after exactly BUSY_TICKS (10) asserted osc_tick cycles counted after the accepting edge.
- R4: While busy, address sets, entry-mode, shift and data reads are ignored: the counter, region, direction and latch keep their values.
- R5: Address set takes three forms, each reducing the value modulo the region depth. Display: rs=00, rw=0, din[7]=1, address din[6:0], depth 80. Glyph: rs=00, rw=0, din[7:6]=01, address din[5:0], depth 64. Attribute: rs=01, rw=0, address din[6:0], depth 80.
- R6: A data read (rs=11, rw=1) returns the latch, which holds the selected memory's byte at the counter value current before the read, and then steps the counter once.
- R7: Entry mode (rs=00, rw=0, din[7:4]=0001) sets the step direction: din[1]=1 counts up, din[1]=0 counts down.
- R8: The counter wraps at the region depth: upward from depth-1 to 0, downward from 0 to depth-1 (80 for display and attribute, 64 for glyph).
- R9: Shift (rs=00, rw=0, din[7:4]=0010) leaves the counter unchanged, makes the port busy, and reloads the latch so the next data read returns the byte at the current counter.
- R10: Consecutive data reads return successive entries along the step direction.
- R11: The unused codes have no effect: data_out keeps its value, busy stays low and the counter does not move. These codes are rs=00 or 01 with rw=1, rs=11 with rw=0, and a command byte with din[7:4]=0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Oscillator enable, one cycle per oscillator period |
| req | input | 1 | Instruction strobe, one cycle per instruction |
| rs | input | 2 | Register select |
| rw | input | 1 | 1 = read, 0 = write |
| din | input | 8 | Instruction or address byte |
| dout | output | 8 | Registered read result (status or data) |

## Verification
The assertions assume two things about the inputs. First, req, rs, rw, din and osc_tick carry known values on every edge after reset. Second, the counter can only be loaded through the reducing address-set path, so it always lies below the selected region's depth. The stimulus drives every input on the falling edge, holds req for exactly one cycle per instruction, and sends no new work other than status polls until a status read shows the flag clear. The only exception is the deliberate test of instructions dropped while busy. The sweeps pass every raw address byte for each region through the reducing path, and they walk the read sequences past the wrap point in both directions.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [1:0] {
    REG_DISP = 2'd0,
    REG_ATTR = 2'd1,
    REG_CGEN = 2'd2
  } region_e;

  typedef struct packed {
    logic status;
    logic rd;
    logic set_addr;
    logic entry;
    logic shift;
  } op_t;

  // start-up fill pattern of each memory region
  function automatic logic [7:0] fill_val(input int unsigned r, input int unsigned i);
    int unsigned v;
    case (r)
      0:       v = i * 3 + 1;
      1:       v = i ^ 32'hA5;
      default: v = i * 7 + 64;
    endcase
    return v[7:0];
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
#(
  parameter int AC_W = 7,
  localparam int DW = AC_W + 1
) (
  input  logic            req,
  input  logic            busy,
  input  logic [1:0]      rs,
  input  logic            rw,
  input  logic [DW-1:0]   din,
  output op_t             op,
  output region_e         set_region,
  output logic [AC_W-1:0] set_addr,
  output logic            set_inc
);

  logic [3:0] opc;
  assign opc = din[DW-1:DW-4];

  always_comb begin
    op         = '0;
    set_region = REG_DISP;
    set_addr   = din[AC_W-1:0];
    set_inc    = din[1];
    if (req) begin
      unique case ({rs, rw})
        3'b101: op.status = 1'b1;
        3'b111: op.rd = !busy;
        3'b010: begin
          op.set_addr = !busy;
          set_region  = REG_ATTR;
        end
        3'b000: begin
          if (din[DW-1]) begin
            op.set_addr = !busy;
            set_region  = REG_DISP;
          end else if (din[DW-1:DW-2] == 2'b01) begin
            op.set_addr = !busy;
            set_region  = REG_CGEN;
            set_addr    = {1'b0, din[DW-3:0]};
          end else if (opc == 4'b0001) begin
            op.entry = !busy;
          end else if (opc == 4'b0010) begin
            op.shift = !busy;
          end
        end
        default: op = '0;
      endcase
    end
  end

endmodule

// File: rtl/lcdc_busy_timer.sv
module lcdc_busy_timer #(
  parameter int BUSY_TICKS = 10,
  localparam int CNT_W = (BUSY_TICKS > 1) ? $clog2(BUSY_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic osc_tick,
  output logic busy_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && osc_tick) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the tick counter never passes the configured length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3: busy cannot drop without an oscillator tick
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !osc_tick) |=> busy_q);

endmodule

// File: rtl/lcdc_addr_ctr.sv
module lcdc_addr_ctr
  import lcdc_pkg::*;
#(
  parameter int AC_W     = 7,
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy_i,
  input  op_t             op,
  input  region_e         set_region,
  input  logic [AC_W-1:0] set_addr,
  input  logic            set_inc,
  output logic [AC_W-1:0] ac_q,
  output region_e         region_q,
  output logic            inc_q
);

  localparam logic [AC_W-1:0] DD_LAST = AC_W'(DD_DEPTH - 1);
  localparam logic [AC_W-1:0] CG_LAST = AC_W'(CG_DEPTH - 1);

  function automatic logic [AC_W-1:0] last_of(input region_e r);
    return (r == REG_CGEN) ? CG_LAST : DD_LAST;
  endfunction

  logic [AC_W-1:0] set_mod;
  logic [AC_W-1:0] step_val;
  logic [AC_W-1:0] cur_last;
  int unsigned     raw;

  always_comb begin
    raw = 32'(set_addr);
    if (set_region == REG_CGEN) set_mod = AC_W'(raw % CG_DEPTH);
    else                        set_mod = AC_W'(raw % DD_DEPTH);
  end

  always_comb begin
    cur_last = last_of(region_q);
    if (inc_q) step_val = (ac_q == cur_last) ? '0 : ac_q + 1'b1;
    else       step_val = (ac_q == '0) ? cur_last : ac_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q     <= '0;
      region_q <= REG_DISP;
      inc_q    <= 1'b1;
    end else begin
      if (op.set_addr) begin
        ac_q     <= set_mod;
        region_q <= set_region;
      end else if (op.rd) begin
        ac_q <= step_val;
      end
      if (op.entry) inc_q <= set_inc;
    end
  end

  // R8: the counter stays inside the selected region
  a_r8_ac_in_range: assert property (@(posedge clk) disable iff (rst)
    (region_q != 2'd3) && (ac_q <= last_of(region_q)));

  // R4: nothing moves while the port is busy
  a_r4_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(ac_q) && $stable(region_q) && $stable(inc_q)));

endmodule

// File: rtl/lcdc_ram_bank.sv
module lcdc_ram_bank
  import lcdc_pkg::*;
#(
  parameter int AC_W     = 7,
  parameter int DD_DEPTH = 80,
  parameter int CG_DEPTH = 64,
  localparam int DW = AC_W + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_en,
  input  region_e         region,
  input  logic [AC_W-1:0] addr,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] qv [3];
  region_e       rsel_q;

  for (genvar g = 0; g < 3; g++) begin : gen_mem
    localparam int D  = (g == 2) ? CG_DEPTH : DD_DEPTH;
    localparam int IW = (D > 1) ? $clog2(D) : 1;

    logic [DW-1:0] mem [D];
    logic [DW-1:0] q;

    initial begin
      for (int i = 0; i < D; i++) mem[i] = fill_val(g, i);
    end

    always_ff @(posedge clk) begin
      if (fetch_en && (region == region_e'(g))) q <= mem[addr[IW-1:0]];
    end

    assign qv[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)           rsel_q <= REG_DISP;
    else if (fetch_en) rsel_q <= region;
  end

  always_comb begin
    case (rsel_q)
      REG_ATTR: rdata = qv[1];
      REG_CGEN: rdata = qv[2];
      default:  rdata = qv[0];
    endcase
  end

endmodule

// File: rtl/lcdc_host_rd.sv
module lcdc_host_rd
  import lcdc_pkg::*;
#(
  parameter int AC_W       = 7,
  parameter int DD_DEPTH   = 80,
  parameter int CG_DEPTH   = 64,
  parameter int BUSY_TICKS = 10,
  localparam int DW = AC_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_tick,
  input  logic          req,
  input  logic [1:0]    rs,
  input  logic          rw,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  op_t             op;
  region_e         set_region;
  logic [AC_W-1:0] set_addr;
  logic            set_inc;
  logic            busy_q;
  logic            start;
  logic [AC_W-1:0] ac_q;
  region_e         region_q;
  logic            inc_q;
  logic            fetch_q;
  logic [DW-1:0]   latch;

  lcdc_decode #(.AC_W(AC_W)) dec_i (
    .req(req), .busy(busy_q), .rs(rs), .rw(rw), .din(din),
    .op(op), .set_region(set_region), .set_addr(set_addr), .set_inc(set_inc)
  );

  assign start = op.rd | op.set_addr | op.entry | op.shift;

  lcdc_busy_timer #(.BUSY_TICKS(BUSY_TICKS)) tmr_i (
    .clk(clk), .rst(rst), .start(start), .osc_tick(osc_tick), .busy_q(busy_q)
  );

  lcdc_addr_ctr #(.AC_W(AC_W), .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) ctr_i (
    .clk(clk), .rst(rst), .busy_i(busy_q), .op(op),
    .set_region(set_region), .set_addr(set_addr), .set_inc(set_inc),
    .ac_q(ac_q), .region_q(region_q), .inc_q(inc_q)
  );

  // refetch one cycle after the counter settles; reset preloads entry 0
  always_ff @(posedge clk) begin
    if (rst) fetch_q <= 1'b1;
    else     fetch_q <= op.rd | op.set_addr | op.shift;
  end

  lcdc_ram_bank #(.AC_W(AC_W), .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) ram_i (
    .clk(clk), .rst(rst), .fetch_en(fetch_q), .region(region_q),
    .addr(ac_q), .rdata(latch)
  );

  always_ff @(posedge clk) begin
    if (rst)            dout <= '0;
    else if (op.status) dout <= {busy_q, ac_q};
    else if (op.rd)     dout <= latch;
  end

  // R3: accepted work always raises busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);

  // R2: a status read from idle leaves the port idle
  a_r2_status_no_start: assert property (@(posedge clk) disable iff (rst)
    (op.status && !busy_q) |=> !busy_q);

  // R4: no work is accepted while busy
  a_r4_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !start);

endmodule

// File: tb/lcdc_host_rd_tb.sv
module lcdc_host_rd_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       req = 1'b0;
  logic [1:0] rs = 2'b00;
  logic       rw = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int div_cnt = 0;
  int cycles = 0;
  logic [7:0] r;
  logic [7:0] last;

  always #10 clk = ~clk;

  lcdc_host_rd dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .req(req),
    .rs(rs), .rw(rw), .din(din), .dout(dout)
  );

  always @(negedge clk) begin
    if (div_cnt >= tick_div - 1) begin
      osc_tick = 1'b1;
      div_cnt  = 0;
    end else begin
      osc_tick = 1'b0;
      div_cnt  = div_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int depth(input int rg);
    return (rg == 2) ? 64 : 80;
  endfunction

  function automatic logic [7:0] fill(input int rg, input int i);
    int v;
    case (rg)
      0:       v = i * 3 + 1;
      1:       v = i ^ 165;
      default: v = i * 7 + 64;
    endcase
    return v[7:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h, expected 0x%0h", tag, act, exp);
    end
  endtask

  // entered on a falling edge; leaves on the next falling edge
  task automatic xfer(input logic [1:0] s, input logic w, input logic [7:0] d,
                      output logic [7:0] q);
    req = 1'b1; rs = s; rw = w; din = d;
    @(negedge clk);
    req = 1'b0;
    q = dout;
  endtask

  task automatic status(output logic [7:0] q);
    xfer(2'b10, 1'b1, 8'h00, q);
  endtask

  task automatic wait_idle();
    logic [7:0] q;
    for (int k = 0; k < 1000; k++) begin
      status(q);
      if (!q[7]) return;
    end
  endtask

  // back-to-back status polls after an accepted instruction
  task automatic count_busy(output int n);
    logic [7:0] q;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      status(q);
      if (!q[7]) return;
      n = n + 1;
    end
  endtask

  task automatic set_addr(input int rg, input logic [7:0] a);
    logic [7:0] q;
    case (rg)
      0:       xfer(2'b00, 1'b0, {1'b1, a[6:0]}, q);
      1:       xfer(2'b01, 1'b0, {1'b0, a[6:0]}, q);
      default: xfer(2'b00, 1'b0, {2'b01, a[5:0]}, q);
    endcase
  endtask

  task automatic rd(output logic [7:0] q);
    xfer(2'b11, 1'b1, 8'h00, q);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    status(r);
    check("R1 status after reset", r, 8'h00);
    rd(r);
    check("R1 first read is display entry 0", r, fill(0, 0));
    wait_idle();
    status(r);
    check("R6 counter stepped up after read", r, 8'h01);

    // R3: busy length, one tick per cycle
    set_addr(0, 8'd5);
    count_busy(n);
    check("R3 busy polls at tick every cycle", n, 10);
    status(r);
    check("R5 display address set", r, 8'd5);
    check("R2 status read left port idle", r[7], 0);

    // R3: slower oscillator
    tick_div = 3;
    xfer(2'b00, 1'b0, 8'h12, r);
    count_busy(n);
    check("R3 busy polls at tick every 3 cycles", (n >= 28 && n <= 30) ? 1 : 0, 1);
    tick_div = 1;

    // R4: drop work while busy
    set_addr(0, 8'd10);
    set_addr(0, 8'd20);
    rd(r);
    xfer(2'b00, 1'b0, 8'h10, r);
    wait_idle();
    status(r);
    check("R4 counter kept while busy", r, 8'd10);
    rd(r);
    check("R4 latch kept while busy", r, fill(0, 10));
    wait_idle();
    status(r);
    check("R4 direction kept while busy", r, 8'd11);

    // R5/R6: sweep every raw address in each region
    for (int rg = 0; rg < 3; rg++) begin
      for (int a = 0; a < ((rg == 2) ? 64 : 128); a++) begin
        set_addr(rg, 8'(a));
        wait_idle();
        status(r);
        check($sformatf("R5 region %0d set 0x%0h", rg, a), r, (a % depth(rg)));
        rd(r);
        check($sformatf("R6 region %0d read 0x%0h", rg, a), r, fill(rg, a % depth(rg)));
        wait_idle();
      end
    end

    // R10/R8: upward sequence across the wrap
    for (int rg = 0; rg < 3; rg++) begin
      set_addr(rg, 8'(depth(rg) - 2));
      wait_idle();
      for (int k = 0; k < 5; k++) begin
        rd(r);
        check($sformatf("R10 region %0d up read %0d", rg, k), r,
              fill(rg, (depth(rg) - 2 + k) % depth(rg)));
        wait_idle();
      end
      status(r);
      check($sformatf("R8 region %0d wrap up", rg), r, 8'd3);
    end

    // R7/R8: downward sequence across the wrap
    xfer(2'b00, 1'b0, 8'h10, r);
    wait_idle();
    for (int rg = 0; rg < 3; rg++) begin
      set_addr(rg, 8'd2);
      wait_idle();
      for (int k = 0; k < 5; k++) begin
        rd(r);
        check($sformatf("R7 region %0d down read %0d", rg, k), r,
              fill(rg, (2 - k + depth(rg)) % depth(rg)));
        wait_idle();
      end
      status(r);
      check($sformatf("R8 region %0d wrap down", rg), r, depth(rg) - 3);
    end
    xfer(2'b00, 1'b0, 8'h12, r);
    wait_idle();

    // R9: shift holds counter and reloads latch
    set_addr(0, 8'd7);
    wait_idle();
    rd(r);
    check("R9 read before shift", r, fill(0, 7));
    wait_idle();
    xfer(2'b00, 1'b0, 8'h20, r);
    status(r);
    check("R9 shift busy, counter held", r, 8'h88);
    wait_idle();
    status(r);
    check("R9 counter after shift", r, 8'd8);
    rd(r);
    check("R9 read after shift", r, fill(0, 8));
    wait_idle();

    // R11: unused codes
    status(last);
    xfer(2'b00, 1'b1, 8'h00, r);
    check("R11 rs=00 rw=1 dout", r, last);
    xfer(2'b01, 1'b1, 8'h00, r);
    check("R11 rs=01 rw=1 dout", r, last);
    xfer(2'b11, 1'b0, 8'h00, r);
    check("R11 rs=11 rw=0 dout", r, last);
    xfer(2'b00, 1'b0, 8'h30, r);
    check("R11 unknown opcode dout", r, last);
    status(r);
    check("R11 no busy and counter held", r, last);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule